// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a single-transfer SPI master. It moves one word (eight bits by default) at a time. Each bit goes out on the serial output line while a bit comes in on the serial input line, so a transfer is full duplex. The block drives the serial clock and one active-low select line. The select line stays low for exactly as long as the transfer runs.

A group of configuration inputs sets the mode: a core enable, the bit order, the clock idle level (polarity), the sampling edge (phase) and a two-bit rate code. The rate code picks a serial clock of the system clock divided by 4, 16, 64 or 128. The bit order, polarity, phase and rate are captured when a transfer starts and are held until it ends.

A one-cycle start strobe, together with the transmit word, begins a transfer. When the transfer ends, the block raises a done flag and presents the received word. An interrupt output copies the done flag while the interrupt-enable input is high.

Top module: `spi_byte_master`

## Requirements
- R1: Each transfer shifts out all 8 bits of the transmit word on `mosi` and shifts in 8 bits from `miso`. After the transfer, `rx_byte` holds the received word.
- R2: With `cfg_lsb_first`=0, bit 7 is sent first and the first received bit lands in bit 7. With `cfg_lsb_first`=1, bit 0 is sent first and the first received bit lands in bit 0.
- R3: With `cfg_cpha`=0, the first bit is on `mosi` when `ss_n` falls, and both sides sample on the leading (even-numbered) clock edges. With `cfg_cpha`=1, each bit is driven on a leading edge, the first one included, and is sampled on the following trailing edge.
- R4: While no transfer runs, `sck` rests at the level of `cfg_cpol`. A leading edge is a move away from that level.
- R5: Rate code 0, 1, 2 or 3 divides the system clock by 4, 16, 64 or 128. `sck` toggles every div/2 cycles, and `busy` stays high for 8*div cycles.
- R6: `ss_n` is low exactly while `busy` is high. Each transfer makes exactly 16 `sck` transitions and returns `sck` to its idle level.
- R7: While `cfg_enable` is 0, `start` is ignored. Clearing `cfg_enable` during a transfer stops it on the next cycle: `busy` goes to 0, `ss_n` goes to 1, `sck` goes idle, and `done` stays 0.
- R8: `irq` is high exactly when `done` is 1 and `cfg_irq_en` is 1.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither the data sent nor the length of the running transfer.
- R10: `done` rises in the same cycle that `busy` falls at the end of a complete transfer. It stays high until the next accepted start clears it.
- R11: After reset, `busy`=0, `ss_n`=1, `done`=0, `irq`=0 and `rx_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Core enable |
| cfg_irq_en | input | 1 | Gates done onto irq |
| cfg_lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_rate | input | 2 | Rate code: divide by 4, 16, 64 or 128 |
| start | input | 1 | One-cycle transfer request |
| tx_byte | input | 8 | Word to send, taken with start |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | Gated completion request |
| rx_byte | output | 8 | Received word |

## Verification
The bench builds the block with its default parameters: an 8-bit word and the divide table 4, 16, 64 and 128. With these values, even the slowest rate finishes a transfer in 1024 cycles. That keeps all four rates, all four clock modes in both bit orders, a start while busy and a mid-transfer disable within a short run. A behavioural slave in the bench follows the clock edges by itself. It checks the captured bit sequence and the returned word against the configured order and phase.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int XFER_BITS = 8,
  parameter int DIV_C0 = 4,
  parameter int DIV_C1 = 16,
  parameter int DIV_C2 = 64,
  parameter int DIV_C3 = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_irq_en,
  input  logic                 cfg_lsb_first,
  input  logic                 cfg_cpol,
  input  logic                 cfg_cpha,
  input  logic [1:0]           cfg_rate,
  input  logic                 start,
  input  logic [XFER_BITS-1:0] tx_byte,
  input  logic                 miso,
  output logic                 sck,
  output logic                 mosi,
  output logic                 ss_n,
  output logic                 busy,
  output logic                 done,
  output logic                 irq,
  output logic [XFER_BITS-1:0] rx_byte
);
  localparam int EDGES = 2 * XFER_BITS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int M01   = (DIV_C0 > DIV_C1) ? DIV_C0 : DIV_C1;
  localparam int M23   = (DIV_C2 > DIV_C3) ? DIV_C2 : DIV_C3;
  localparam int HMAX  = ((M01 > M23) ? M01 : M23) / 2;
  localparam int CW    = (HMAX > 1) ? $clog2(HMAX) : 1;
  localparam int MSB   = XFER_BITS - 1;

  logic           busy_q, done_q, ph_q, mosi_q;
  logic           cpol_q, cpha_q, lsb_q;
  logic [1:0]     rate_q;
  logic [CW-1:0]  cnt_q, hlim;
  logic [EW-1:0]  edge_q;
  logic [MSB:0]   tx_sh, rx_sh;
  logic           tick, last, samp, accept;

  always_comb begin
    case (rate_q)
      2'd0:    hlim = CW'(DIV_C0 / 2 - 1);
      2'd1:    hlim = CW'(DIV_C1 / 2 - 1);
      2'd2:    hlim = CW'(DIV_C2 / 2 - 1);
      default: hlim = CW'(DIV_C3 / 2 - 1);
    endcase
  end

  assign tick   = busy_q && (cnt_q == hlim);
  assign last   = (edge_q == EW'(EDGES - 1));
  assign samp   = (edge_q[0] == cpha_q);
  assign accept = cfg_enable && start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= 1'b0;
      mosi_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      rate_q <= 2'd0;
      cnt_q  <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      if (!busy_q) begin
        cpol_q <= cfg_cpol;
        cpha_q <= cfg_cpha;
        lsb_q  <= cfg_lsb_first;
        rate_q <= cfg_rate;
      end
      if (!cfg_enable) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
        edge_q <= '0;
      end else if (accept) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        ph_q   <= 1'b0;
        cnt_q  <= '0;
        edge_q <= '0;
        if (!cfg_cpha) begin
          mosi_q <= cfg_lsb_first ? tx_byte[0] : tx_byte[MSB];
          tx_sh  <= cfg_lsb_first ? (tx_byte >> 1) : (tx_byte << 1);
        end else begin
          tx_sh  <= tx_byte;
        end
      end else if (busy_q) begin
        if (tick) begin
          cnt_q  <= '0;
          ph_q   <= ~ph_q;
          edge_q <= edge_q + 1'b1;
          if (samp) begin
            rx_sh <= lsb_q ? {miso, rx_sh[MSB:1]} : {rx_sh[MSB-1:0], miso};
          end else if (cpha_q || !last) begin
            mosi_q <= lsb_q ? tx_sh[0] : tx_sh[MSB];
            tx_sh  <= lsb_q ? (tx_sh >> 1) : (tx_sh << 1);
          end
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck     = cpol_q ^ ph_q;
  assign mosi    = mosi_q;
  assign ss_n    = ~busy_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign irq     = done_q & cfg_irq_en;
  assign rx_byte = rx_sh;

  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !busy_q && !$past(busy_q)) |-> (sck == $past(cfg_cpol))); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable({cpol_q, cpha_q, lsb_q, rate_q})); // R3
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q < EW'(EDGES))); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !busy_q); // R7
  AST_SCK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(sck)) |-> ($past(cnt_q) == $past(hlim))); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && cfg_enable && !tick) |=> (busy_q && $stable(edge_q))); // R9
endmodule

// File: tb/test_spi_byte_master.sv
module test_spi_byte_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_irq_en = 1'b0, cfg_lsb_first = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic start = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic miso = 1'b0;
  logic sck, mosi, ss_n, busy, done, irq;
  logic [7:0] rx_byte;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_rate(cfg_rate), .start(start), .tx_byte(tx_byte), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done), .irq(irq),
    .rx_byte(rx_byte)
  );

  // behavioural slave: sends s_word first bit first, captures in arrival order
  logic [7:0] s_word = 8'h00, s_cap = 8'h00;
  bit s_cpha = 1'b0, s_active = 1'b0;
  int s_edges = 0, s_k = 0;

  always @(negedge ss_n) begin
    s_active = 1'b1;
    s_edges = 0;
    s_k = 0;
    s_cap = 8'h00;
    if (!s_cpha) begin
      miso = s_word[7];
      s_k = 1;
    end
  end

  always @(sck) begin
    if (s_active) begin
      if ((s_edges % 2 == 0) != s_cpha) begin
        s_cap = {s_cap[6:0], mosi};
      end else if (s_k < 8) begin
        miso = s_word[7 - s_k];
        s_k = s_k + 1;
      end
      s_edges = s_edges + 1;
      if (s_edges == 16) s_active = 1'b0;
    end
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sw, input bit lsb,
                          input bit cpol, input bit cpha, input logic [1:0] rate,
                          input bit ien, input int poke);
    int div, cnt;
    bit ss_bad;
    div = (rate == 2'd0) ? 4 : (rate == 2'd1) ? 16 : (rate == 2'd2) ? 64 : 128;
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha; cfg_rate = rate;
    cfg_irq_en = ien; s_cpha = cpha; s_word = sw;
    repeat (3) @(negedge clk);
    chk(sck === cpol, "R4 idle sck level", int'(sck), int'(cpol));
    start = 1'b1; tx_byte = tx;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0, "R10 done cleared by start", int'(done), 0);
    cnt = 0; ss_bad = 1'b0;
    while (busy === 1'b1) begin
      cnt++;
      if (ss_n !== 1'b0) ss_bad = 1'b1;
      start = (cnt == poke);
      tx_byte = (cnt == poke) ? ~tx : tx;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cnt == 8 * div, "R5 transfer length", cnt, 8 * div);
    chk(!ss_bad && ss_n === 1'b1, "R6 select low only while busy", int'(ss_bad), 0);
    chk(s_edges == 16, "R6 sck transition count", s_edges, 16);
    chk(sck === cpol, "R4 sck idle after transfer", int'(sck), int'(cpol));
    chk(s_cap === (lsb ? rev8(tx) : tx), "R1 R2 R3 mosi bit sequence", int'(s_cap),
        int'(lsb ? rev8(tx) : tx));
    chk(rx_byte === (lsb ? rev8(sw) : sw), "R1 R2 R3 received word", int'(rx_byte),
        int'(lsb ? rev8(sw) : sw));
    chk(done === 1'b1, "R10 done at end", int'(done), 1);
    chk(irq === ien, "R8 irq gating", int'(irq), int'(ien));
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && ss_n === 1'b1, "R11 reset busy/ss_n", int'({busy, ss_n}), 1);
    chk(done === 1'b0 && irq === 1'b0, "R11 reset done/irq", int'({done, irq}), 0);
    chk(rx_byte === 8'h00, "R11 reset rx_byte", int'(rx_byte), 0);
  endtask

  task automatic t_modes();
    run_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, -1);
    run_xfer(8'h81, 8'hC3, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, -1);
    run_xfer(8'h1E, 8'h96, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, -1);
    run_xfer(8'hD2, 8'h0F, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, -1);
    run_xfer(8'h6B, 8'hF1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, -1);
    run_xfer(8'h07, 8'h5A, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, -1);
    run_xfer(8'hE3, 8'h88, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, -1);
    run_xfer(8'h35, 8'h71, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, -1);
  endtask

  task automatic t_rates();
    run_xfer(8'h9C, 8'h2B, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, -1);
    run_xfer(8'h4D, 8'hB4, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, -1);
    run_xfer(8'hF0, 8'h0E, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, -1);
  endtask

  task automatic t_busy_start();
    // R9: a start with a different word mid-transfer is ignored
    run_xfer(8'hC6, 8'h39, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 40);
  endtask

  task automatic t_irq_live();
    @(negedge clk);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0 && done === 1'b1, "R8 irq drops with enable", int'(irq), 0);
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R8 irq follows done", int'(irq), 1);
  endtask

  task automatic t_disable();
    logic [7:0] rx_before;
    rx_before = rx_byte;
    @(negedge clk);
    cfg_enable = 1'b0; cfg_cpol = 1'b0; s_cpha = 1'b0; cfg_cpha = 1'b0; cfg_rate = 2'd0;
    repeat (2) @(negedge clk);
    start = 1'b1; tx_byte = 8'h55;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b0 && ss_n === 1'b1, "R7 start ignored when disabled", int'(busy), 0);
    repeat (40) @(negedge clk);
    chk(rx_byte === rx_before && done === 1'b1, "R7 no transfer while disabled",
        int'(rx_byte), int'(rx_before));
    cfg_enable = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b1; tx_byte = 8'hAA;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R7 transfer running before abort", int'(busy), 1);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && ss_n === 1'b1, "R7 abort releases select", int'({busy, ss_n}), 1);
    chk(done === 1'b0 && sck === 1'b0, "R7 abort leaves done low, sck idle",
        int'({done, sck}), 0);
    s_active = 1'b0;
    cfg_enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    cfg_enable = 1'b1;
    repeat (2) @(negedge clk);
    t_modes();
    t_irq_live();
    t_rates();
    t_busy_start();
    t_disable();
    run_xfer(8'h12, 8'hED, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule